// File: doc/BRIEF.md
# Zoned/Packed Decimal Format Converter

This block converts a decimal operand from zoned form to packed form, or from packed form to zoned form. In zoned form each byte carries one digit in its low nibble and a zone code in its high nibble. In packed form each byte carries two digits, and the least significant byte carries one digit and the sign nibble. A function input chooses the direction of conversion. A mode input chooses the zone code that unpacking writes: the EBCDIC code or the ASCII code.

Each operand has its own 4-bit length code L and spans L+1 bytes. The source operand is presented as a flat byte vector and is captured on a start pulse. The block then produces one destination byte per clock, from the least significant byte upward, and pulses `done` when the result vector is complete. A short source is extended with zero digits, and a long source is cut off at the destination length.

Top module: `dec_zone_pack_conv`

## Requirements
- R1: Byte i of `src_bytes` and `dst_bytes` occupies bits [8i+7:8i], and byte 0 is the least significant. An operand with length code L spans bytes 0..L. Function, mode, lengths and `src_bytes` are captured on the edge that accepts `start`, and later changes to these inputs do not affect the run.
- R2: When packing (`fn_unpack`=0), destination byte 0 is source byte 0 with its two nibbles exchanged.
- R3: When packing, destination byte k≥1 takes the low nibble of source byte 2k-1 as its low nibble and the low nibble of source byte 2k as its high nibble. Source zone nibbles are discarded.
- R4: Any source byte whose index exceeds the source length code supplies zero digits. This holds in both directions.
- R5: Destination bytes above the destination length code read 00 after a run, and source digits that do not fit the destination are dropped.
- R6: When unpacking (`fn_unpack`=1), destination byte 0 is source byte 0 with its two nibbles exchanged.
- R7: When unpacking, destination byte k≥1 holds a digit in its low nibble. For odd k the digit is the low nibble of source byte (k+1)/2. For even k the digit is the high nibble of source byte k/2.
- R8: When unpacking, the high nibble of every destination byte k≥1 is 4'hF when `ascii_mode`=0 and 4'h5 when `ascii_mode`=1.
- R9: `done` is high for exactly one cycle. It is first seen high after the (L1+2)th rising edge, counting the edge that accepts `start` as the first, where L1 is the destination length code.
- R10: A `start` pulse that arrives while a conversion is running is ignored and does not change that run's result or its timing.
- R11: After reset, `done` is 0 and `dst_bytes` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a conversion when the block is idle |
| fn_unpack | input | 1 | 0 = pack zoned to packed, 1 = unpack packed to zoned |
| ascii_mode | input | 1 | Zone code when unpacking: 0 = F, 1 = 5 |
| dst_len | input | 4 | Destination length code L1 (L1+1 bytes) |
| src_len | input | 4 | Source length code L2 (L2+1 bytes) |
| src_bytes | input | 128 | Source operand, byte 0 least significant |
| dst_bytes | output | 128 | Result operand, valid when `done` pulses |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its default 16-byte arrays. With this size the full length-code space is small enough to sweep completely. Every pairing of destination and source length, in both directions and both zone modes, is run against a fresh pseudo-random operand. Every destination byte is compared with a value the bench derives from the nibble placement rules. The sweep therefore covers zero extension, truncation, the single-byte cases and full 16-byte operands. The bench also measures the latency of every run, and separately tests a second start pulse and source changes during a run.

// File: rtl/dec_conv_pkg.sv
package dec_conv_pkg;
  typedef enum logic {
    FN_PACK   = 1'b0,
    FN_UNPACK = 1'b1
  } conv_fn_e;

  localparam logic [3:0] ZONE_EBCDIC = 4'hF;
  localparam logic [3:0] ZONE_ASCII  = 4'h5;

  function automatic logic [7:0] nib_swap(input logic [7:0] b);
    return {b[3:0], b[7:4]};
  endfunction
endpackage

// File: rtl/dcv_sequencer.sv
module dcv_sequencer
  import dec_conv_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             fn_in,
  input  logic             ascii_in,
  input  logic [LEN_W-1:0] dlen_in,
  output logic             load,
  output conv_fn_e         fn_q,
  output logic             ascii_q,
  output logic [LEN_W-1:0] idx,
  output logic             wr_en,
  output logic             done
);
  logic             busy;
  logic [LEN_W-1:0] dlen_q;
  logic             last;

  assign load  = start && !busy;
  assign wr_en = busy;
  assign last  = busy && (idx == dlen_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      idx     <= '0;
      dlen_q  <= '0;
      fn_q    <= FN_PACK;
      ascii_q <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= last;
      if (load) begin
        busy    <= 1'b1;
        idx     <= '0;
        dlen_q  <= dlen_in;
        fn_q    <= conv_fn_e'(fn_in);
        ascii_q <= ascii_in;
      end else if (busy) begin
        if (last) busy <= 1'b0;
        else      idx  <= idx + 1'b1;
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (idx <= dlen_q)); // R5
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy)); // R9
  AST_BUSY_START_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> ($stable(dlen_q) && $stable(fn_q) && $stable(ascii_q))); // R10
endmodule

// File: rtl/dcv_src_store.sv
module dcv_src_store #(
  parameter int MAX_BYTES = 16,
  parameter int LEN_W     = 4,
  parameter int RIDX_W    = LEN_W + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic [MAX_BYTES*8-1:0] src_flat,
  input  logic [LEN_W-1:0]       src_len,
  input  logic [RIDX_W-1:0]      rd_idx_a,
  input  logic [RIDX_W-1:0]      rd_idx_b,
  output logic [7:0]             byte_a,
  output logic [7:0]             byte_b
);
  logic [7:0]       mem [MAX_BYTES];
  logic [LEN_W-1:0] len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
      for (int i = 0; i < MAX_BYTES; i++) mem[i] <= 8'h00;
    end else if (load) begin
      len_q <= src_len;
      for (int i = 0; i < MAX_BYTES; i++) mem[i] <= src_flat[i*8 +: 8];
    end
  end

  // Indices past the captured length read as zero digits.
  always_comb begin
    byte_a = 8'h00;
    byte_b = 8'h00;
    if (rd_idx_a <= {1'b0, len_q}) byte_a = mem[rd_idx_a[LEN_W-1:0]];
    if (rd_idx_b <= {1'b0, len_q}) byte_b = mem[rd_idx_b[LEN_W-1:0]];
  end

  AST_LEN_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    (len_q <= LEN_W'(MAX_BYTES - 1))); // R1
endmodule

// File: rtl/dcv_byte_gen.sv
module dcv_byte_gen
  import dec_conv_pkg::*;
#(
  parameter int LEN_W  = 4,
  parameter int RIDX_W = LEN_W + 1
) (
  input  conv_fn_e          fn,
  input  logic              ascii,
  input  logic [LEN_W-1:0]  idx,
  input  logic [7:0]        byte_a,
  input  logic [7:0]        byte_b,
  output logic [RIDX_W-1:0] rd_idx_a,
  output logic [RIDX_W-1:0] rd_idx_b,
  output logic [7:0]        out_byte
);
  logic [RIDX_W-1:0] twice;
  logic [3:0]        zone;
  logic [3:0]        digit;

  assign twice = {idx, 1'b0};
  assign zone  = ascii ? ZONE_ASCII : ZONE_EBCDIC;

  always_comb begin
    rd_idx_a = '0;
    rd_idx_b = '0;
    digit    = 4'h0;
    out_byte = 8'h00;
    if (idx == '0) begin
      out_byte = nib_swap(byte_a);
    end else if (fn == FN_PACK) begin
      rd_idx_a = twice - 1'b1;
      rd_idx_b = twice;
      out_byte = {byte_b[3:0], byte_a[3:0]};
    end else begin
      if (idx[0]) begin
        rd_idx_a = (RIDX_W'(idx) + 1'b1) >> 1;
        digit    = byte_a[3:0];
      end else begin
        rd_idx_a = RIDX_W'(idx) >> 1;
        digit    = byte_a[7:4];
      end
      out_byte = {zone, digit};
    end
  end
endmodule

// File: rtl/dcv_dst_store.sv
module dcv_dst_store #(
  parameter int MAX_BYTES = 16,
  parameter int LEN_W     = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear,
  input  logic                   wr_en,
  input  logic [LEN_W-1:0]       wr_idx,
  input  logic [7:0]             wr_byte,
  output logic [MAX_BYTES*8-1:0] dst_flat
);
  logic [7:0] mem [MAX_BYTES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MAX_BYTES; i++) mem[i] <= 8'h00;
    end else if (clear) begin
      for (int i = 0; i < MAX_BYTES; i++) mem[i] <= 8'h00;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_byte;
    end
  end

  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_flat
    assign dst_flat[g*8 +: 8] = mem[g];
  end

  AST_CLEAR_NOT_DURING_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !clear); // R10
endmodule

// File: rtl/dec_zone_pack_conv.sv
module dec_zone_pack_conv
  import dec_conv_pkg::*;
#(
  parameter int MAX_BYTES = 16,
  parameter int LEN_W     = $clog2(MAX_BYTES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   fn_unpack,
  input  logic                   ascii_mode,
  input  logic [LEN_W-1:0]       dst_len,
  input  logic [LEN_W-1:0]       src_len,
  input  logic [MAX_BYTES*8-1:0] src_bytes,
  output logic [MAX_BYTES*8-1:0] dst_bytes,
  output logic                   done
);
  localparam int RIDX_W = LEN_W + 1;

  logic              load;
  conv_fn_e          fn_q;
  logic              ascii_q;
  logic [LEN_W-1:0]  idx;
  logic              wr_en;
  logic [RIDX_W-1:0] rd_idx_a, rd_idx_b;
  logic [7:0]        byte_a, byte_b, out_byte;

  dcv_sequencer #(.LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .fn_in(fn_unpack),
    .ascii_in(ascii_mode), .dlen_in(dst_len), .load(load), .fn_q(fn_q),
    .ascii_q(ascii_q), .idx(idx), .wr_en(wr_en), .done(done)
  );

  dcv_src_store #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W), .RIDX_W(RIDX_W)) u_src (
    .clk(clk), .rst_n(rst_n), .load(load), .src_flat(src_bytes),
    .src_len(src_len), .rd_idx_a(rd_idx_a), .rd_idx_b(rd_idx_b),
    .byte_a(byte_a), .byte_b(byte_b)
  );

  dcv_byte_gen #(.LEN_W(LEN_W), .RIDX_W(RIDX_W)) u_gen (
    .fn(fn_q), .ascii(ascii_q), .idx(idx), .byte_a(byte_a), .byte_b(byte_b),
    .rd_idx_a(rd_idx_a), .rd_idx_b(rd_idx_b), .out_byte(out_byte)
  );

  dcv_dst_store #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) u_dst (
    .clk(clk), .rst_n(rst_n), .clear(load), .wr_en(wr_en), .wr_idx(idx),
    .wr_byte(out_byte), .dst_flat(dst_bytes)
  );

  AST_ZONE_ON_UNPACK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fn_q == FN_UNPACK && idx != '0) |=>
      (dst_bytes[$past(idx)*8 + 4 +: 4] == (ascii_q ? 4'h5 : 4'hF))); // R8
endmodule

// File: tb/dec_zone_pack_conv_test.sv
module dec_zone_pack_conv_test;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          fn_unpack = 1'b0;
  logic          ascii_mode = 1'b0;
  logic [3:0]    dst_len = '0;
  logic [3:0]    src_len = '0;
  logic [NB*8-1:0] src_bytes = '0;
  logic [NB*8-1:0] dst_bytes;
  logic          done;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  dec_zone_pack_conv uut (
    .clk(clk), .rst_n(rst_n), .start(start), .fn_unpack(fn_unpack),
    .ascii_mode(ascii_mode), .dst_len(dst_len), .src_len(src_len),
    .src_bytes(src_bytes), .dst_bytes(dst_bytes), .done(done)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  function automatic logic [127:0] rand_src();
    logic [127:0] v;
    for (int w = 0; w < 4; w++) begin
      seed = seed * 32'd1664525 + 32'd1013904223;
      v[w*32 +: 32] = seed;
    end
    return v;
  endfunction

  function automatic logic [3:0] nib(input logic [127:0] s, input int l2,
                                     input int j, input bit hi);
    if (j > l2) return 4'h0;
    return hi ? s[j*8+4 +: 4] : s[j*8 +: 4];
  endfunction

  function automatic logic [7:0] exp_byte(input bit f, input bit a, input int l1,
                                          input int l2, input logic [127:0] s,
                                          input int k);
    if (k > l1) return 8'h00;
    if (k == 0) return {s[3:0], s[7:4]};
    if (!f) return {nib(s, l2, 2*k, 0), nib(s, l2, 2*k-1, 0)};
    if (k % 2 == 1) return {(a ? 4'h5 : 4'hF), nib(s, l2, (k+1)/2, 0)};
    return {(a ? 4'h5 : 4'hF), nib(s, l2, k/2, 1)};
  endfunction

  function automatic string tag(input bit f, input int l1, input int l2, input int k);
    if (k > l1) return "R5";
    if (k == 0) return f ? "R6" : "R2";
    if (!f && 2*k-1 > l2) return "R4";
    if (f && ((k % 2 == 1) ? (k+1)/2 : k/2) > l2) return "R4";
    if (l1 == 15 && l2 == 15) return "R1";
    return f ? "R7_R8" : "R3";
  endfunction

  task automatic run_conv(input bit f, input bit a, input int l1, input int l2,
                          input logic [127:0] s, input bit disturb);
    int n;
    @(negedge clk);
    start = 1; fn_unpack = f; ascii_mode = a;
    dst_len = 4'(l1); src_len = 4'(l2); src_bytes = s;
    @(negedge clk);
    start = 0;
    n = 1;
    while (!done && n < 40) begin
      if (disturb && n == 2) begin
        start = 1; fn_unpack = ~f; ascii_mode = ~a; dst_len = 4'(15 - l1);
        src_len = 4'(15 - l2); src_bytes = ~s;
      end else if (disturb && n == 3) begin
        start = 0;
      end
      @(negedge clk);
      n++;
    end
    check(n == l1 + 2, disturb ? "R10 latency" : "R9 latency", 128'(n), 128'(l1 + 2));
    for (int k = 0; k < NB; k++) begin
      logic [7:0] e;
      e = exp_byte(f, a, l1, l2, s, k);
      check(dst_bytes[k*8 +: 8] == e, disturb ? "R10 byte" : tag(f, l1, l2, k),
            128'(dst_bytes[k*8 +: 8]), 128'(e));
    end
    @(negedge clk);
    check(done == 1'b0, "R9 pulse width", 128'(done), 128'(0));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R11 done", 128'(done), 128'(0));
    check(dst_bytes == '0, "R11 dst", dst_bytes, 128'(0));
    rst_n = 1;
    @(negedge clk);
    for (int f = 0; f < 2; f++)
      for (int a = 0; a < 2; a++)
        for (int l1 = 0; l1 < 16; l1++)
          for (int l2 = 0; l2 < 16; l2++)
            run_conv(f[0], a[0], l1, l2, rand_src(), 1'b0);
    run_conv(1'b0, 1'b0, 15, 15, rand_src(), 1'b1);
    run_conv(1'b1, 1'b1, 12, 5, rand_src(), 1'b1);
    run_conv(1'b1, 1'b0, 0, 9, 128'h0123_4567_89ab_cdef_0123_4567_89ab_cd3c, 1'b0);
    report();
  end
endmodule